// File: doc/BRIEF.md
# Serial stereo audio receiver

This block takes a three-wire serial audio stream (a bit clock, a word clock and a data line) and turns it into two parallel 16-bit two's complement words, one for each stereo channel. The three wires are asynchronous to the block's own clock, which is a system clock at 384 times the sample rate. Each wire passes through a two-flop synchroniser, and all edge detection happens in the system clock domain.

Data bits are shifted in, most significant bit first, on each bit-clock rising edge. While the word clock is high the incoming bits belong to channel 1, and while it is low they belong to channel 2. Each word-clock transition captures the current shift-register contents as the word for the channel that has just ended. When the channel-2 word is captured, both output words are updated in the same cycle and a one-cycle pair strobe marks a complete stereo sample.

An active-low initialisation input, sampled on the system clock, clears the block. Surrounding logic should hold it low for at least one full word-clock period after power and clocks are stable.

Top module: `stereo_serial_rx`

## Requirements
- R1: Each channel word is 16 bits, two's complement, and the first bit received in a channel period ends up as bit 15 of the output word.
- R2: A data bit is taken only at a bit-clock rising edge. Changes on the data line while the bit clock is high or low have no effect on the received word.
- R3: Bits received while the word clock is high form `ch1_word`, and bits received while it is low form `ch2_word`.
- R4: A word consists of the last 16 bits shifted in before its closing word-clock transition. Any earlier bits in that channel period are discarded.
- R5: `pair_strobe` goes high for exactly one system-clock cycle at each word-clock rising edge that closes a channel-2 period. `ch1_word` and `ch2_word` take their new values in that same cycle.
- R6: Between pair strobes, `ch1_word` and `ch2_word` hold their values, including across the channel-1 capture at the word-clock falling edge.
- R7: While `init_n` is low, both words read zero and no strobe is issued. After release, no strobe is issued until a channel-1 word has been captured by a word-clock falling edge, so a word-clock rising edge that comes first is ignored.
- R8: With the default two synchroniser stages, `pair_strobe` is high in the cycle after the third system-clock rising edge following the word-clock rise. It is low after the second and the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 384 times the sample rate |
| init_n | input | 1 | Synchronous active-low initialisation |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Word clock: high for channel 1, low for channel 2 |
| sdata_in | input | 1 | Serial data, MSB first |
| ch1_word | output | 16 | Last complete channel-1 word |
| ch2_word | output | 16 | Last complete channel-2 word |
| pair_strobe | output | 1 | One-cycle pulse when a new stereo pair is presented |

## Verification
The bench sends the following patterns:
- **Walking-one sweep.** A single set bit walks through every position on channel 1, with its complement on channel 2. This separates bit order from channel steering.
- **Extremes.** All zeros, all ones, and the most positive and most negative codes confirm the two's complement reading.
- **Pseudo-random pairs with extra bits.** Pairs are preceded by extra leading bits of the opposite polarity. These show that only the final 16 bits count.
- **Glitching data line.** On every bit, the data line flips while the bit clock is high, so a receiver that samples on the wrong phase gives the wrong word.
- **Initialisation.** Initialisation is asserted mid-frame. A word-clock rise is then sent without a prior fall, which separates correct arming from a stray strobe.
- **Strobe latency.** A cycle-exact probe around one word-clock rise pins the synchroniser latency.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned SSR_WORD_W = 16;
  localparam int unsigned SSR_SYNC_N = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge (
  input  logic          clk,
  input  logic          init_n,
  input  logic          level,
  output ssr_pkg::edge_t ev
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= level;
  end

  assign ev.rise = level & ~prev_q;
  assign ev.fall = ~level & prev_q;

  // R8: an edge is flagged for a single cycle only
  assert_one_cycle_edge_R8: assert property (@(posedge clk) disable iff (!init_n)
    ev.rise |=> !ev.rise);
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!init_n)       word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end
endmodule

// File: rtl/ssr_pair.sv
module ssr_pair #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              wclk_rise,
  input  logic              wclk_fall,
  input  logic [WORD_W-1:0] shift_word,
  output logic [WORD_W-1:0] ch1_q,
  output logic [WORD_W-1:0] ch2_q,
  output logic              strobe_q
);
  logic [WORD_W-1:0] ch1_hold_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (!init_n) begin
      ch1_hold_q <= '0;
      armed_q    <= 1'b0;
      ch1_q      <= '0;
      ch2_q      <= '0;
      strobe_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (wclk_fall) begin
        ch1_hold_q <= shift_word;
        armed_q    <= 1'b1;
      end
      if (wclk_rise && armed_q) begin
        ch1_q    <= ch1_hold_q;
        ch2_q    <= shift_word;
        strobe_q <= 1'b1;
      end
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!init_n)
    strobe_q |=> !strobe_q);

  assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!init_n)
    strobe_q |-> $past(wclk_rise));

  assert_ch2_source_R3: assert property (@(posedge clk) disable iff (!init_n)
    strobe_q |-> ch2_q == $past(shift_word));

  assert_words_hold_R6: assert property (@(posedge clk) disable iff (!init_n)
    ($past(init_n) && !strobe_q) |-> $stable({ch1_q, ch2_q}));
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int unsigned WORD_W      = ssr_pkg::SSR_WORD_W,
  parameter int unsigned SYNC_STAGES = ssr_pkg::SSR_SYNC_N
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              bclk_in,
  input  logic              wclk_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] ch1_word,
  output logic [WORD_W-1:0] ch2_word,
  output logic              pair_strobe
);
  localparam int unsigned LINES = 3;

  logic [LINES-1:0]  sync_lines;
  logic              bclk_s, wclk_s, sdata_s;
  ssr_pkg::edge_t    bclk_ev, wclk_ev;
  logic [WORD_W-1:0] shift_word;

  ssr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in ({bclk_in, wclk_in, sdata_in}),
    .sync_out (sync_lines)
  );

  assign {bclk_s, wclk_s, sdata_s} = sync_lines;

  ssr_edge u_bclk_edge (.clk(clk), .init_n(init_n), .level(bclk_s), .ev(bclk_ev));
  ssr_edge u_wclk_edge (.clk(clk), .init_n(init_n), .level(wclk_s), .ev(wclk_ev));

  ssr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .init_n   (init_n),
    .shift_en (bclk_ev.rise),
    .din      (sdata_s),
    .word     (shift_word)
  );

  ssr_pair #(.WORD_W(WORD_W)) u_pair (
    .clk        (clk),
    .init_n     (init_n),
    .wclk_rise  (wclk_ev.rise),
    .wclk_fall  (wclk_ev.fall),
    .shift_word (shift_word),
    .ch1_q      (ch1_word),
    .ch2_q      (ch2_word),
    .strobe_q   (pair_strobe)
  );
endmodule

// File: tb/stereo_serial_rx_test.sv
module stereo_serial_rx_test;
  localparam int W = 16;
  localparam int H = 4;

  logic         clk = 1'b0;
  logic         init_n = 1'b0;
  logic         bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [W-1:0] ch1_word, ch2_word;
  logic         pair_strobe;
  int           total = 0, bad = 0, strobes = 0;

  always #4 clk = ~clk;

  stereo_serial_rx uut (
    .clk(clk), .init_n(init_n), .bclk_in(bclk), .wclk_in(wclk), .sdata_in(sdata),
    .ch1_word(ch1_word), .ch2_word(ch2_word), .pair_strobe(pair_strobe)
  );

  always @(posedge clk) if (pair_strobe) strobes <= strobes + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: data flips while bit clock is high; only the rising-edge value counts
  task automatic send_bit(input logic b);
    bclk = 1'b0; sdata = b; wait_n(H);
    bclk = 1'b1; wait_n(H/2);
    sdata = ~b;  wait_n(H - H/2);
  endtask

  task automatic send_word(input logic [W-1:0] w, input int pre);
    for (int i = 0; i < pre; i++) send_bit(~w[W-1]);
    for (int i = W-1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_halves(input logic [W-1:0] c1, input logic [W-1:0] c2, input int pre);
    logic [W-1:0] o1, o2;
    o1 = ch1_word; o2 = ch2_word;
    bclk = 1'b0; wclk = 1'b1;
    send_word(c1, pre);
    chk(ch1_word == o1 && ch2_word == o2, "R6 hold before capture", ch1_word, o1);
    bclk = 1'b0; wclk = 1'b0;
    send_word(c2, pre);
    wait_n(4);
    chk(ch1_word == o1 && ch2_word == o2, "R6 hold after ch1 capture", ch2_word, o2);
  endtask

  task automatic send_pair(input logic [W-1:0] c1, input logic [W-1:0] c2, input int pre);
    int s0;
    send_halves(c1, c2, pre);
    s0 = strobes;
    bclk = 1'b0; wclk = 1'b1;
    wait_n(6);
    chk(strobes == s0 + 1, "R5 one strobe per pair", strobes - s0, 1);
    chk(ch1_word == c1, pre > 0 ? "R4 ch1 last 16 bits" : "R3 ch1 word", ch1_word, c1);
    chk(ch2_word == c2, pre > 0 ? "R4 ch2 last 16 bits" : "R3 ch2 word", ch2_word, c2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    logic [W-1:0] a, b;
    logic [31:0] lcg;
    wait_n(10);
    chk(ch1_word == 0 && ch2_word == 0 && !pair_strobe, "R7 reset state", {ch1_word, ch2_word}, 0);
    init_n = 1'b1;
    // R7: rise without a preceding fall must not strobe
    s0 = strobes;
    send_word(16'h1234, 0);
    bclk = 1'b0; wclk = 1'b1; wait_n(8);
    chk(strobes == s0, "R7 no strobe before arming", strobes - s0, 0);
    chk(ch2_word == 0, "R7 words still zero", ch2_word, 0);

    // R1: walking one, complement on the other channel
    for (int k = 0; k < W; k++) send_pair(16'(1 << k), ~16'(1 << k), 0);
    send_pair(16'h0000, 16'hFFFF, 0);
    chk($signed(ch2_word) == -1, "R1 two's complement -1", ch2_word, 16'hFFFF);
    send_pair(16'h7FFF, 16'h8000, 0);
    chk($signed(ch1_word) == 32767 && $signed(ch2_word) == -32768, "R1 extremes", {ch1_word, ch2_word}, 32'h7FFF8000);

    // R4: pseudo-random pairs with extra leading bits
    lcg = 32'h1ACE_B00C;
    for (int n = 0; n < 12; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg[31:16];
      lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg[31:16];
      send_pair(a, b, 1 + (n % 5));
    end

    // R8: cycle-exact strobe latency
    send_halves(16'hA5C3, 16'h3C5A, 0);
    bclk = 1'b0; wclk = 1'b1;
    wait_n(2);
    chk(pair_strobe == 1'b0, "R8 low after 2 edges", pair_strobe, 0);
    wait_n(1);
    chk(pair_strobe == 1'b1, "R8 high after 3 edges", pair_strobe, 1);
    chk(ch1_word == 16'hA5C3 && ch2_word == 16'h3C5A, "R5 words update with strobe", {ch1_word, ch2_word}, 32'hA5C33C5A);
    wait_n(1);
    chk(pair_strobe == 1'b0, "R8 low after 4 edges", pair_strobe, 0);

    // R7: init mid-frame clears and suppresses strobes
    send_word(16'h0F0F, 0);
    s0 = strobes;
    init_n = 1'b0;
    wait_n(2);
    chk(ch1_word == 0 && ch2_word == 0, "R7 cleared by init", {ch1_word, ch2_word}, 0);
    bclk = 1'b0; wclk = 1'b0; send_word(16'h1111, 0);
    wclk = 1'b1; wait_n(8);
    wclk = 1'b0; wait_n(8);
    chk(strobes == s0 && ch1_word == 0, "R7 no strobe during init", strobes - s0, 0);
    init_n = 1'b1;
    send_word(16'h2222, 0);
    bclk = 1'b0; wclk = 1'b1; wait_n(8);
    chk(strobes == s0, "R7 first rise after init ignored", strobes - s0, 0);
    send_pair(16'hBEEF, 16'h0123, 0);
    send_pair(16'h8001, 16'h7FFE, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule